// File: doc/BRIEF.md
# BCD Time-of-Day Clock with Alarm

This block keeps a 12-hour wall-clock time in packed BCD across four byte registers: tenths of a second, seconds, minutes, and hours with an AM/PM flag. A mains-derived line tick (50 or 60 Hz) is divided down to one tenths step. The hours register rolls over from 12 to 1. The meridian flag flips when the time passes from 11:59:59.9 to 12:00:00.0.

A host reaches the registers through a simple byte port. A read of hours freezes a copy of all four registers, so that minutes, seconds and tenths can be read one at a time without a carry slipping in between. A read of tenths releases the copy, and the clock keeps counting while the copy is held. When the host sets the time, a write of hours stops the count and a write of tenths starts it again, so a load sequence ending with tenths is atomic. A select input sends writes to a separate alarm register set instead. The alarm registers cannot be read back. A match between the running time and the alarm produces a one-cycle flag pulse for an interrupt controller.

Top module: `tod_clock`

## Requirements
- R1: After reset the time reads hours 0x12, minutes 0x00, seconds 0x00, tenths 0x00 (12:00:00.0 AM), the clock runs, and alarm_o is low.
- R2: The time advances by one tenth on every 6th line tick when rate_50_i is 0 and on every 5th when it is 1. A time write to tenths restarts the tick count from zero.
- R3: Register addresses are 0 = tenths, 1 = seconds, 2 = minutes, 3 = hours. Tenths counts 0..9 in bits 3:0. Seconds and minutes count 0x00..0x59, with tens in bits 6:4 and ones in bits 3:0. Each carries into the next field when it wraps.
- R4: Hours holds 1..12 in BCD, with tens in bit 4 and ones in bits 3:0. Bit 7 is 1 for PM. Hours steps from 12 to 1, and bit 7 toggles exactly when 11:59:59.9 advances to 12:00:00.0.
- R5: A read (rd_en_i) of address 3 freezes what all four addresses return. A read of address 0 releases the freeze. Time counted during the freeze is visible after the release.
- R6: A time write (alarm_sel_i = 0) to address 3 stops the clock, and a time write to address 0 restarts it. Written bits outside the field layout of R3/R4 read back as 0.
- R7: Writes with alarm_sel_i = 1 go to the alarm registers only. They leave the time and the running state unchanged.
- R8: alarm_o pulses high for exactly one cycle, in the cycle after a tenths step whose new time equals the alarm value in all four registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Line-frequency tick, one cycle wide per period |
| rate_50_i | input | 1 | Tick rate select: 0 = 60 Hz, 1 = 50 Hz |
| alarm_sel_i | input | 1 | Write target: 0 = time, 1 = alarm |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (drives the freeze side effects) |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| alarm_o | output | 1 | Alarm match pulse |

## Verification
A fault in the BCD carry chain shows up at rdata_o the first time the faulty digit wraps. The bench therefore loads random times and runs them across hundreds of steps, and also drives the hour and meridian rollovers directly. A stuck freeze or halt flag changes the next four-register read after ticks have been applied. A wrong prescaler count shows as a tenths value off by one within a single step window. Alarm faults appear as a pulse count that differs from the bench model at the end of each run.

// File: rtl/tod_pkg.sv
package tod_pkg;
  typedef struct packed {
    logic [7:0] hr;
    logic [7:0] mn;
    logic [7:0] sc;
    logic [7:0] te;
  } tod_t;

  localparam logic [1:0] A_TE = 2'd0;
  localparam logic [1:0] A_SC = 2'd1;
  localparam logic [1:0] A_MN = 2'd2;
  localparam logic [1:0] A_HR = 2'd3;

  localparam logic [7:0] M_TE = 8'h0F;
  localparam logic [7:0] M_MS = 8'h7F;
  localparam logic [7:0] M_HR = 8'h9F;

  localparam tod_t TOD_RST = '{hr: 8'h12, mn: 8'h00, sc: 8'h00, te: 8'h00};

  // {carry, value} for a 00..59 BCD field
  function automatic logic [8:0] inc_sexa(input logic [7:0] v);
    logic [8:0] r;
    if (v[3:0] >= 4'd9) begin
      if (v[6:4] >= 3'd5) r = 9'h100;
      else                r = {1'b0, 1'b0, v[6:4] + 3'd1, 4'd0};
    end else begin
      r = {1'b0, 1'b0, v[6:4], v[3:0] + 4'd1};
    end
    return r;
  endfunction

  function automatic logic [7:0] inc_hr(input logic [7:0] v);
    logic [7:0] r;
    if (v[4:0] == 5'h12)      r = {v[7], 7'h01};
    else if (v[4:0] == 5'h11) r = {~v[7], 7'h12};
    else if (v[3:0] >= 4'd9)  r = {v[7], 7'h10};
    else                      r = {v[7], 2'b00, v[4], v[3:0] + 4'd1};
    return r;
  endfunction
endpackage

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
  parameter int DIV60 = 6,
  parameter int DIV50 = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rate_50_i,
  input  logic clear_i,
  output logic adv_o
);
  localparam int DMAX = (DIV60 > DIV50) ? DIV60 : DIV50;
  localparam int W    = $clog2(DMAX + 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] last;

  assign last  = rate_50_i ? W'(DIV50 - 1) : W'(DIV60 - 1);
  assign adv_o = tick_i & ~clear_i & (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (tick_i)  cnt_q <= adv_o ? '0 : cnt_q + W'(1);
  end
endmodule

// File: rtl/tod_time_core.sv
module tod_time_core
  import tod_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       adv_i,
  input  logic       wr_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output tod_t       time_o,
  output tod_t       next_o,
  output logic       step_o,
  output logic       halted_o
);
  tod_t time_q, nxt;
  logic halted_q;
  logic [8:0] sc_inc, mn_inc;
  logic te_wrap;

  always_comb begin
    nxt     = time_q;
    te_wrap = time_q.te[3:0] >= 4'd9;
    sc_inc  = inc_sexa(time_q.sc);
    mn_inc  = inc_sexa(time_q.mn);
    nxt.te  = te_wrap ? 8'h00 : {4'h0, time_q.te[3:0] + 4'd1};
    if (te_wrap) begin
      nxt.sc = sc_inc[7:0];
      if (sc_inc[8]) begin
        nxt.mn = mn_inc[7:0];
        if (mn_inc[8]) nxt.hr = inc_hr(time_q.hr);
      end
    end
  end

  assign step_o   = adv_i & ~halted_q & ~wr_i;
  assign time_o   = time_q;
  assign next_o   = nxt;
  assign halted_o = halted_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q   <= TOD_RST;
      halted_q <= 1'b0;
    end else if (wr_i) begin
      unique case (addr_i)
        A_TE: begin time_q.te <= wdata_i & M_TE; halted_q <= 1'b0; end
        A_SC: time_q.sc <= wdata_i & M_MS;
        A_MN: time_q.mn <= wdata_i & M_MS;
        A_HR: begin time_q.hr <= wdata_i & M_HR; halted_q <= 1'b1; end
        default: ;
      endcase
    end else if (step_o) begin
      time_q <= nxt;
    end
  end
endmodule

// File: rtl/tod_read_latch.sv
module tod_read_latch
  import tod_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rd_i,
  input  logic [1:0] addr_i,
  input  tod_t       live_i,
  output logic [7:0] rdata_o,
  output logic       latched_o,
  output tod_t       snap_o
);
  tod_t snap_q, view;
  logic latched_q;

  assign view = latched_q ? snap_q : live_i;

  always_comb begin
    unique case (addr_i)
      A_TE:    rdata_o = view.te;
      A_SC:    rdata_o = view.sc;
      A_MN:    rdata_o = view.mn;
      default: rdata_o = view.hr;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q    <= TOD_RST;
      latched_q <= 1'b0;
    end else if (rd_i) begin
      if (addr_i == A_HR && !latched_q) begin
        snap_q    <= live_i;
        latched_q <= 1'b1;
      end else if (addr_i == A_TE) begin
        latched_q <= 1'b0;
      end
    end
  end

  assign latched_o = latched_q;
  assign snap_o    = snap_q;
endmodule

// File: rtl/tod_clock.sv
module tod_clock
  import tod_pkg::*;
#(
  parameter int DIV60 = 6,
  parameter int DIV50 = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rate_50_i,
  input  logic       alarm_sel_i,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       alarm_o
);
  logic time_wr, alarm_wr, adv, step, halted_w, latched_w, presc_clr;
  tod_t live, next_t, snap_w, alarm_q;

  assign time_wr   = wr_en_i & ~alarm_sel_i;
  assign alarm_wr  = wr_en_i & alarm_sel_i;
  assign presc_clr = halted_w | (time_wr & (addr_i == A_TE));

  tod_prescaler #(.DIV60(DIV60), .DIV50(DIV50)) u_presc (
    .clk_i, .rst_ni, .tick_i, .rate_50_i,
    .clear_i(presc_clr), .adv_o(adv)
  );

  tod_time_core u_core (
    .clk_i, .rst_ni, .adv_i(adv), .wr_i(time_wr), .addr_i, .wdata_i,
    .time_o(live), .next_o(next_t), .step_o(step), .halted_o(halted_w)
  );

  tod_read_latch u_rd (
    .clk_i, .rst_ni, .rd_i(rd_en_i), .addr_i, .live_i(live),
    .rdata_o, .latched_o(latched_w), .snap_o(snap_w)
  );

  // hours 0x00 never occurs in a running clock, so reset value never matches
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alarm_q <= '0;
      alarm_o <= 1'b0;
    end else begin
      if (alarm_wr) begin
        unique case (addr_i)
          A_TE: alarm_q.te <= wdata_i & M_TE;
          A_SC: alarm_q.sc <= wdata_i & M_MS;
          A_MN: alarm_q.mn <= wdata_i & M_MS;
          default: alarm_q.hr <= wdata_i & M_HR;
        endcase
      end
      alarm_o <= step && (next_t == alarm_q);
    end
  end
endmodule

// File: rtl/tod_clock_chk.sv
module tod_clock_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        alarm_o,
  input logic        wr_en_i,
  input logic        rd_en_i,
  input logic        alarm_sel_i,
  input logic [1:0]  addr_i,
  input logic        halted,
  input logic        latched,
  input logic [31:0] snap,
  input logic [31:0] live
);
  AST_ALARM_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o |=> !alarm_o); // R8
  AST_HR_WRITE_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !alarm_sel_i && addr_i == 2'd3) |=> halted); // R6
  AST_TE_WRITE_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !alarm_sel_i && addr_i == 2'd0) |=> !halted); // R6
  AST_HALT_HOLDS_TIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted && !wr_en_i) |=> $stable(live)); // R6
  AST_HR_READ_FREEZES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == 2'd3) |=> latched); // R5
  AST_TE_READ_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == 2'd0) |=> !latched); // R5
  AST_SNAP_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latched |=> $stable(snap)); // R5
  AST_ALARM_WR_KEEPS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && alarm_sel_i) |=> (halted == $past(halted))); // R7
endmodule

bind tod_clock tod_clock_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .alarm_o(alarm_o), .wr_en_i(wr_en_i),
  .rd_en_i(rd_en_i), .alarm_sel_i(alarm_sel_i), .addr_i(addr_i),
  .halted(halted_w), .latched(latched_w), .snap(snap_w), .live(live)
);

// File: tb/tod_clock_tb.sv
module tod_clock_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, rate50 = 0, asel = 0, wr = 0, rd = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic alarm;

  tod_clock u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rate_50_i(rate50),
    .alarm_sel_i(asel), .wr_en_i(wr), .rd_en_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .alarm_o(alarm)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0, alarm_seen = 0, alarm_exp = 0;
  bit done = 0;
  // model
  int m_h = 12, m_pm = 0, m_m = 0, m_s = 0, m_t = 0, pcnt = 0;
  bit halted = 0;
  logic [7:0] al_b [4] = '{8'h00, 8'h00, 8'h00, 8'h00};

  always @(negedge clk) if (rst_n && alarm) alarm_seen++;

  function automatic logic [7:0] bcd(int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction
  function automatic int unbcd(logic [7:0] b);
    return int'(b[6:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic logic [7:0] enc(int a);
    case (a)
      0: return bcd(m_t);
      1: return bcd(m_s);
      2: return bcd(m_m);
      default: return bcd(m_h) | (m_pm ? 8'h80 : 8'h00);
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic model_step();
    m_t++;
    if (m_t == 10) begin m_t = 0; m_s++; end
    if (m_s == 60) begin m_s = 0; m_m++; end
    if (m_m == 60) begin
      m_m = 0;
      if (m_h == 11) begin m_h = 12; m_pm ^= 1; end
      else if (m_h == 12) m_h = 1;
      else m_h++;
    end
    if (enc(0) == al_b[0] && enc(1) == al_b[1] && enc(2) == al_b[2] && enc(3) == al_b[3])
      alarm_exp++;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
      if (!halted) begin
        pcnt++;
        if (pcnt >= (rate50 ? 5 : 6)) begin pcnt = 0; model_step(); end
      end
    end
  endtask

  task automatic wr_reg(bit alm, int a, logic [7:0] d);
    @(negedge clk); wr = 1; asel = alm; addr = 2'(a); wdata = d;
    @(negedge clk); wr = 0; asel = 0;
    if (alm) begin
      case (a)
        0: al_b[0] = d & 8'h0F;
        1: al_b[1] = d & 8'h7F;
        2: al_b[2] = d & 8'h7F;
        default: al_b[3] = d & 8'h9F;
      endcase
    end else begin
      case (a)
        0: begin m_t = int'(d[3:0]); halted = 0; pcnt = 0; end
        1: m_s = unbcd(d);
        2: m_m = unbcd(d);
        default: begin m_h = int'(d[4]) * 10 + int'(d[3:0]); m_pm = d[7]; halted = 1; end
      endcase
    end
  endtask

  task automatic rd_reg(int a, output logic [7:0] v);
    @(negedge clk); rd = 1; addr = 2'(a);
    #1 v = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic load(int h, int pm, int m, int s, int t);
    wr_reg(0, 3, bcd(h) | (pm ? 8'h80 : 8'h00) | 8'(($urandom & 3) << 5));
    wr_reg(0, 2, bcd(m) | (($urandom & 1) ? 8'h80 : 8'h00));
    wr_reg(0, 1, bcd(s) | (($urandom & 1) ? 8'h80 : 8'h00));
    wr_reg(0, 0, bcd(t) | 8'(($urandom & 15) << 4));
  endtask

  task automatic read_all(string req);
    logic [7:0] v;
    logic [7:0] e [4];
    for (int a = 0; a < 4; a++) e[a] = enc(a);
    rd_reg(3, v); chk({req, " hours"}, v, e[3]);
    rd_reg(2, v); chk({req, " minutes"}, v, e[2]);
    rd_reg(1, v); chk({req, " seconds"}, v, e[1]);
    rd_reg(0, v); chk({req, " tenths"}, v, e[0]);
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, frz [4];
    void'($urandom(32'h5eed_7d0c));
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 alarm low", alarm, 0);
    read_all("R1 reset");

    // R2 prescaler at both rates
    for (int r = 0; r < 2; r++) begin
      rate50 = r[0];
      load(3, 0, 10, 20, 4);
      ticks(r ? 4 : 5);
      rd_reg(0, v); chk("R2 no step before divide", v, 8'h04);
      ticks(1);
      rd_reg(0, v); chk("R2 step at divide", v, 8'h05);
    end

    // R3/R4 directed rollovers
    rate50 = 0;
    load(11, 0, 59, 59, 9); ticks(6); read_all("R4 AM to PM at noon");
    load(11, 1, 59, 59, 9); ticks(6); read_all("R4 PM to AM");
    load(12, 1, 59, 59, 9); ticks(6); read_all("R4 12 to 1 keeps meridian");
    load(9, 0, 59, 59, 9);  ticks(6); read_all("R4 9 to 10");
    load(5, 0, 7, 59, 8);   ticks(12); read_all("R3 seconds carry");

    // R5 freeze while reading
    load(2, 0, 30, 15, 0);
    ticks(3);
    for (int a = 0; a < 4; a++) frz[a] = enc(a);
    rd_reg(3, v); chk("R5 hours at freeze", v, frz[3]);
    ticks(60);
    rd_reg(2, v); chk("R5 minutes frozen", v, frz[2]);
    rd_reg(1, v); chk("R5 seconds frozen", v, frz[1]);
    rd_reg(0, v); chk("R5 tenths frozen", v, frz[0]);
    read_all("R5 after release");

    // R6 halt on hours write, resume on tenths write
    wr_reg(0, 3, 8'h87);
    ticks(30);
    read_all("R6 halted");
    wr_reg(0, 0, 8'h02);
    ticks(13);
    read_all("R6 resumed");

    // R7 alarm writes leave time and run state alone
    wr_reg(1, 3, 8'h08); wr_reg(1, 2, 8'h00);
    wr_reg(1, 1, 8'h00); wr_reg(1, 0, 8'h00);
    read_all("R7 after alarm write");
    ticks(12);
    read_all("R7 still running");

    // R8 alarm match two steps ahead
    load(4, 1, 0, 0, 7);
    wr_reg(1, 3, 8'h84); wr_reg(1, 2, 8'h00);
    wr_reg(1, 1, 8'h00); wr_reg(1, 0, 8'h09);
    alarm_seen = 0; alarm_exp = 0;
    ticks(18);
    chk("R8 single alarm pulse", alarm_seen, 1);
    chk("R8 alarm count vs model", alarm_seen, alarm_exp);

    // random runs
    for (int it = 0; it < 24; it++) begin
      int h, pm, mi, s, t;
      rate50 = $urandom & 1;
      h = 1 + ($urandom % 12); pm = $urandom & 1;
      mi = $urandom % 60; s = $urandom % 60; t = $urandom % 10;
      if (it % 3 == 0) begin mi = 59; s = 58; end
      load(h, pm, mi, s, t);
      wr_reg(1, 3, enc(3)); wr_reg(1, 2, enc(2));
      wr_reg(1, 1, enc(1)); wr_reg(1, 0, bcd((m_t + 1 + ($urandom % 3)) % 10));
      alarm_seen = 0; alarm_exp = 0;
      ticks($urandom % 700);
      read_all("R3 R4 random");
      chk("R8 random alarm count", alarm_seen, alarm_exp);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule